// File: doc/BRIEF.md
# Program Memory Access Controller

This block sits between a processor's program-memory port and two memories: an on-chip RAM and an off-chip memory. Every access carries a 14-bit word address, and the block routes it to one of three places. These are the on-chip RAM port, the off-chip port, or a small control register. The control register sits at the top word of the space and holds the number of wait states used for off-chip accesses.

A strap input is captured while reset is held. It chooses one of two layouts. With the strap low, the on-chip RAM sits at the bottom of the space and the processor must load it, so the block pulses a boot request once reset is released. With the strap high, off-chip memory starts at address zero, the on-chip RAM moves to the top of the space, and no boot request is raised.

On-chip RAM and register accesses finish in the cycle they are requested. An off-chip access is latched and held on the off-chip port. The block keeps `ready` low for the programmed number of cycles and then returns the off-chip read data with `ready` high. The size of the on-chip RAM is a parameter: 2K words by default, and 1K words in the smaller variant.

Top module: `pmem_ctrl`

## Requirements
- R1: The control register answers at the all-ones word address (0x3FFF) in both layouts, and it takes priority over on-chip RAM there. Its wait-state field is bits [2:0]. A read returns the field in `rdata[2:0]` with all other bits zero. A write with `we` high loads `wdata[2:0]` at the clock edge.
- R2: After reset the wait-state field reads 7.
- R3: With the strap captured low, addresses below INT_WORDS go to the on-chip RAM. Every other address except 0x3FFF goes off-chip.
- R4: With the strap captured high, addresses from 2^14 − INT_WORDS up to 0x3FFE go to the on-chip RAM. Every lower address goes off-chip.
- R5: On-chip RAM and register accesses raise `ready` in the request cycle. In that cycle, `rdata` carries `int_rdata` for an on-chip read.
- R6: An off-chip access that is requested while the field holds N keeps `ready` low in the request cycle and for N more cycles. It raises `ready` for exactly one cycle after that. For the whole access, `ext_en` stays high and `ext_addr`, `ext_we` and `ext_wdata` hold the request's values. In the ready cycle, `rdata` carries `ext_rdata`.
- R7: A request made while an off-chip access is pending, including during its ready cycle, is ignored. It raises no `int_en` and does not write the control register.
- R8: The strap is sampled only while `rst_n` is low. Changing it afterwards has no effect on decoding until the next reset.
- R9: `boot_req` is high for exactly one cycle, the second cycle after `rst_n` goes high, and only when the captured strap is low. Otherwise it stays low.
- R10: The on-chip RAM size comes from the INT_WORDS parameter. With 1024 words, the decoding rules of R3 and R4 apply with 1024 in place of 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_sel | input | 1 | Layout strap, captured during reset |
| req | input | 1 | Access request |
| we | input | 1 | Write enable for the request |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| ready | output | 1 | Access complete |
| boot_req | output | 1 | One-cycle request to load on-chip RAM |
| int_en | output | 1 | On-chip RAM select |
| int_we | output | 1 | On-chip RAM write strobe |
| int_addr | output | INT_AW | On-chip RAM word address |
| int_wdata | output | DATA_W | On-chip RAM write data |
| int_rdata | input | DATA_W | On-chip RAM read data |
| ext_en | output | 1 | Off-chip select, held for the whole access |
| ext_we | output | 1 | Off-chip write strobe |
| ext_addr | output | ADDR_W | Off-chip word address |
| ext_wdata | output | DATA_W | Off-chip write data |
| ext_rdata | input | DATA_W | Off-chip read data |

## Verification
The decode is swept over all 16384 addresses in both layouts, on a 2K instance and a 1K instance side by side. The strap is toggled throughout each sweep. The two instances disagree only in the window between 1K and 2K, which separates a sizing error from a layout error, and the toggled strap shows any sampling of it outside reset. Off-chip accesses are repeated for every wait count from 0 to 7, and the position of the ready cycle is counted against each count. While each access is pending, the bench offers on-chip reads and register writes to show they are ignored. Resets with each strap value separate a correct boot pulse from a missing or stray one.

// File: rtl/pmem_pkg.sv
`timescale 1ns/1ps
// Shared types for the program memory access controller.
package pmem_pkg;
    // Destination chosen for one access.
    typedef enum logic [1:0] {
        TGT_INT = 2'd0,
        TGT_EXT = 2'd1,
        TGT_REG = 2'd2
    } tgt_e;
endpackage

// File: rtl/pmem_decode.sv
`timescale 1ns/1ps
// Address decoder: maps a word address to on-chip RAM, off-chip memory or
// the control register, according to the captured layout bit.
// Assumes INT_WORDS is a power of two no larger than half the space.
module pmem_decode
    import pmem_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int INT_AW = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_hi,
    output tgt_e              tgt,
    output logic [INT_AW-1:0] int_addr
);
    localparam int TAG_W = ADDR_W - INT_AW;

    logic [TAG_W-1:0] tag;
    logic             low_hit;
    logic             high_hit;
    logic             reg_hit;
    logic             ram_hit;

    assign tag      = addr[ADDR_W-1:INT_AW];
    assign int_addr = addr[INT_AW-1:0];
    assign reg_hit  = &addr;
    assign low_hit  = (tag == '0);
    assign high_hit = &tag;

    // Pick the RAM window for the layout in force.
    always_comb begin
        ram_hit = map_hi ? high_hit : low_hit;
    end

    // Register outranks RAM; everything else goes off-chip.
    always_comb begin
        if (reg_hit)      tgt = TGT_REG;
        else if (ram_hit) tgt = TGT_INT;
        else              tgt = TGT_EXT;
    end
endmodule

// File: rtl/pmem_sysreg.sv
`timescale 1ns/1ps
// Control register and reset-time logic: holds the wait-state field,
// captures the layout strap during reset and issues the boot pulse.
// Assumes rst_n is synchronous to clk.
module pmem_sysreg #(
    parameter int          WAIT_W   = 3,
    parameter logic [WAIT_W-1:0] WAIT_RST = 3'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap,
    input  logic              wr_en,
    input  logic [WAIT_W-1:0] wr_val,
    output logic [WAIT_W-1:0] wait_q,
    output logic              map_hi,
    output logic              boot_req
);
    logic armed_q;

    // Wait-state field: reset to the maximum, load on register write.
    always_ff @(posedge clk) begin
        if (!rst_n)     wait_q <= WAIT_RST;
        else if (wr_en) wait_q <= wr_val;
    end

    // Strap capture: follows the pin only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) map_hi <= strap;
    end

    // Boot pulse: one cycle after the first clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            boot_req <= 1'b0;
        end else begin
            armed_q  <= 1'b1;
            boot_req <= !armed_q && !map_hi;
        end
    end

    a_r2_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> wait_q == WAIT_RST);
    a_r8_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(map_hi));
    a_r9_boot_single: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |=> !boot_req);
    a_r9_boot_layout: assert property (@(posedge clk) disable iff (!rst_n)
        boot_req |-> !map_hi);
endmodule

// File: rtl/pmem_waiter.sv
`timescale 1ns/1ps
// Off-chip access sequencer: latches an accepted off-chip request and
// counts the programmed wait states, flagging the final (ready) cycle.
// Assumes start is only raised while busy is low.
module pmem_waiter #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              last,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              lat_we,
    output logic [DATA_W-1:0] lat_wdata
);
    logic [WAIT_W-1:0] cnt;

    // Sequencer state: load on start, count down, release after ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= wait_n;
        end
    end

    // Request latch: captured once per accepted off-chip access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_wdata <= '0;
        end else if (start && !busy) begin
            lat_addr  <= addr;
            lat_we    <= we;
            lat_wdata <= wdata;
        end
    end

    assign last = busy && (cnt == '0);

    a_r6_load_count: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(start) && !$past(busy) |-> busy && cnt == $past(wait_n));
    a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(busy) && busy |-> $stable(lat_addr) && $stable(lat_we) && $stable(lat_wdata));
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
endmodule

// File: rtl/pmem_ctrl.sv
`timescale 1ns/1ps
// Program memory access controller (top). Routes each request to on-chip
// RAM, off-chip memory or the control register. Off-chip accesses are
// stretched by the programmed wait count, and requests made while one is
// pending are dropped. Assumes on-chip RAM reads are combinational and
// the requester keeps req high until it sees ready.
module pmem_ctrl
    import pmem_pkg::*;
#(
    parameter int                ADDR_W    = 14,
    parameter int                DATA_W    = 16,
    parameter int                INT_WORDS = 2048,
    parameter int                WAIT_W    = 3,
    parameter logic [WAIT_W-1:0] WAIT_RST  = 3'd7,
    localparam int               INT_AW    = $clog2(INT_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sel,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output logic              boot_req,
    output logic              int_en,
    output logic              int_we,
    output logic [INT_AW-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic [DATA_W-1:0] int_rdata,
    output logic              ext_en,
    output logic              ext_we,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata
);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};
    localparam int                RAM_BASE = (1 << ADDR_W) - INT_WORDS;

    tgt_e              tgt;
    logic              map_hi;
    logic [WAIT_W-1:0] wait_q;
    logic              busy;
    logic              last;
    logic              acc;
    logic              reg_wr;
    logic              start;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;

    pmem_decode #(.ADDR_W(ADDR_W), .INT_AW(INT_AW)) u_dec (
        .addr     (addr),
        .map_hi   (map_hi),
        .tgt      (tgt),
        .int_addr (int_addr)
    );

    pmem_sysreg #(.WAIT_W(WAIT_W), .WAIT_RST(WAIT_RST)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap    (map_sel),
        .wr_en    (reg_wr),
        .wr_val   (wdata[WAIT_W-1:0]),
        .wait_q   (wait_q),
        .map_hi   (map_hi),
        .boot_req (boot_req)
    );

    pmem_waiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wait_n    (wait_q),
        .addr      (addr),
        .we        (we),
        .wdata     (wdata),
        .busy      (busy),
        .last      (last),
        .lat_addr  (lat_addr),
        .lat_we    (lat_we),
        .lat_wdata (lat_wdata)
    );

    // Acceptance: a request counts only while no off-chip access is pending.
    always_comb begin
        acc    = req && !busy;
        int_en = acc && (tgt == TGT_INT);
        int_we = int_en && we;
        reg_wr = acc && we && (tgt == TGT_REG);
        start  = acc && (tgt == TGT_EXT);
    end

    assign int_wdata = wdata;

    // Off-chip port: live request in its first cycle, latched copy after.
    always_comb begin
        ext_en    = start || busy;
        ext_addr  = busy ? lat_addr  : addr;
        ext_we    = busy ? lat_we    : (start && we);
        ext_wdata = busy ? lat_wdata : wdata;
    end

    // Completion and read data return.
    always_comb begin
        ready = last || (acc && (tgt != TGT_EXT));
        if (last)                               rdata = ext_rdata;
        else if (acc && tgt == TGT_INT)         rdata = int_rdata;
        else if (acc && tgt == TGT_REG)         rdata = {{(DATA_W-WAIT_W){1'b0}}, wait_q};
        else                                    rdata = '0;
    end

    a_r1_reg_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(reg_wr) |-> wait_q == $past(wdata[WAIT_W-1:0]));
    a_r1_reg_addr: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> addr == TOP_ADDR);
    a_r3_low_window: assert property (@(posedge clk) disable iff (!rst_n)
        int_en && !map_hi |-> int'(addr) < INT_WORDS);
    a_r4_high_window: assert property (@(posedge clk) disable iff (!rst_n)
        int_en && map_hi |-> int'(addr) >= RAM_BASE && addr != TOP_ADDR);
    a_r5_int_ready: assert property (@(posedge clk) disable iff (!rst_n)
        int_en |-> ready);
    a_r6_single_port: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_en, ext_en}));
    a_r7_drop_pending: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !int_en && !reg_wr);
endmodule

// File: tb/sim_pmem_ctrl.sv
`timescale 1ns/1ps
module sim_pmem_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sel = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [13:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] int_rdata = 16'hC3C3;
    logic [15:0] ext_rdata = 16'h3C3C;

    logic [15:0] rdata0, rdata1, iw0, iw1, ewd0, ewd1;
    logic        rdy0, rdy1, boot0, boot1, ien0, ien1, iwe0, iwe1;
    logic        een0, een1, ewe0, ewe1;
    logic [10:0] ia0;
    logic [9:0]  ia1;
    logic [13:0] ea0, ea1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk; // 50 MHz

    pmem_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata0), .ready(rdy0), .boot_req(boot0),
        .int_en(ien0), .int_we(iwe0), .int_addr(ia0), .int_wdata(iw0), .int_rdata(int_rdata),
        .ext_en(een0), .ext_we(ewe0), .ext_addr(ea0), .ext_wdata(ewd0), .ext_rdata(ext_rdata));

    pmem_ctrl #(.INT_WORDS(1024)) u1 (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata1), .ready(rdy1), .boot_req(boot1),
        .int_en(ien1), .int_we(iwe1), .int_addr(ia1), .int_wdata(iw1), .int_rdata(int_rdata),
        .ext_en(een1), .ext_we(ewe1), .ext_addr(ea1), .ext_wdata(ewd1), .ext_rdata(ext_rdata));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Reset with a given strap, then check the boot pulse (R9) and reset value (R2).
    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; map_sel = s; req = 1'b0; we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2 chk("R9 boot low before pulse", {boot0, boot1}, 2'b00);
        @(negedge clk);
        #2 chk("R9 boot pulse", {boot0, boot1}, s ? 2'b00 : 2'b11);
        @(negedge clk);
        #2 chk("R9 boot single cycle", {boot0, boot1}, 2'b00);
        req = 1'b1; addr = 14'h3FFF;
        #2 chk("R2 reset wait field", rdata0, 16'd7);
        chk("R2 reset wait field 1K", rdata1, 16'd7);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wr_reg(input logic [15:0] v);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 14'h3FFF; wdata = v;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd_reg(input string tag, input logic [15:0] exp);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 14'h3FFF;
        #2 chk(tag, rdata0, exp);
        chk(tag, {31'd0, rdy0}, 32'd1);
        @(negedge clk);
        req = 1'b0;
    endtask

    // Full decode sweep in one layout, strap toggled throughout (R3, R4, R8, R10).
    task automatic sweep(input logic m);
        for (int a = 0; a < 16384; a++) begin
            logic i0, i1, rg;
            @(negedge clk);
            map_sel = ~map_sel;
            req = 1'b1; we = 1'b0; addr = a[13:0];
            rg = (a == 16383);
            i0 = !rg && (m ? (a >= 16384 - 2048) : (a < 2048));
            i1 = !rg && (m ? (a >= 16384 - 1024) : (a < 1024));
            #2;
            chk(m ? "R4 int select" : "R3 int select", {31'd0, ien0}, {31'd0, i0});
            chk(m ? "R4 ext select" : "R3 ext select", {31'd0, een0}, {31'd0, !i0 && !rg});
            chk("R10 int select 1K", {31'd0, ien1}, {31'd0, i1});
            chk("R10 ext select 1K", {31'd0, een1}, {31'd0, !i1 && !rg});
            chk("R5 R6 ready in request cycle", {31'd0, rdy0}, {31'd0, i0 || rg});
            if (i0) begin
                chk("R5 int read data", rdata0, 16'hC3C3);
                chk("R3 R4 int address", ia0, a[10:0]);
            end
            if (rg) chk("R1 reg read", rdata0, 16'd0);
            @(negedge clk);
            req = 1'b0;
        end
        map_sel = m;
    endtask

    // One off-chip access with wait count n; foreign requests offered meanwhile (R6, R7).
    task automatic ext_access(input int n);
        wr_reg(n[15:0]);
        rd_reg("R1 reg readback", n[15:0]);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 14'h0123; wdata = 16'hBEEF;
        #2 chk("R6 request cycle ready low", {31'd0, rdy0}, 32'd0);
        chk("R6 request cycle ext select", {31'd0, een0}, 32'd1);
        for (int k = 0; k <= n; k++) begin
            @(negedge clk);
            we = 1'b1; wdata = 16'h0005;
            addr = (k % 2 == 0) ? 14'h3800 : 14'h3FFF;
            #2;
            chk("R6 ready timing", {31'd0, rdy0}, {31'd0, k == n});
            chk("R6 held address", ea0, 14'h0123);
            chk("R6 held write", {ewe0, ewd0}, {1'b1, 16'hBEEF});
            chk("R6 held select", {31'd0, een0}, 32'd1);
            chk("R7 no int while pending", {31'd0, ien0}, 32'd0);
            if (k == n) chk("R6 ext read data", rdata0, 16'h3C3C);
        end
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        #2 chk("R6 released", {31'd0, een0}, 32'd0);
        rd_reg("R7 reg unchanged", n[15:0]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R6 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        do_reset(1'b0);
        wr_reg(16'h0000);
        sweep(1'b0);
        do_reset(1'b1);
        wr_reg(16'h0000);
        sweep(1'b1);
        map_sel = 1'b0;
        for (int n = 0; n < 8; n++) ext_access(n);
        // Write with upper bits set: only the field is kept (R1).
        wr_reg(16'hFFFA);
        rd_reg("R1 field only", 16'h0002);
        do_reset(1'b0);
        summary();
        $finish;
    end
endmodule